// File: doc/BRIEF.md
# Byte-Lane Peripheral Bus Bridge

This block connects a single 32-bit bus master to a set of peripherals whose data ports are only eight bits wide. It follows the Wishbone classic single-cycle handshake. Each peripheral owns an address window, and each window is given at instantiation as a base value and a mask. The bridge finds the window that the master's address falls into and raises that peripheral's cycle and strobe. The address and the write-enable pass through to every peripheral unchanged.

The two low address bits pick a byte lane, and the lanes are numbered big-endian. On a write, the byte in the chosen lane of the master's 32-bit data word goes to the peripheral's 8-bit input. On a read, the peripheral's byte is placed back into that same lane of the 32-bit word, and the other three lanes read as zero. Acknowledge and error come back only from the peripheral that was chosen.

No peripheral acts as a fallback. An address outside every window selects nothing, and the master gets no answer. The bridge has no registers: every output is a combinational function of the present inputs.

Top module: `byte_bus_bridge`

## Requirements
- R1: While m_cyc_i is high and the address satisfies (m_adr_i & MASK_k) == BASE_k for exactly one slave k, s_cyc_o has only bit k set and s_stb_o[k] equals m_stb_i. Slave k's BASE_k and MASK_k are the slices [k*AW +: AW] of SLV_BASE and SLV_MASK.
- R2: When several windows match, only the lowest-numbered matching slave is selected, and s_cyc_o never has more than one bit set.
- R3: When no window matches, s_cyc_o and s_stb_o are all zero, m_ack_o and m_err_o are low, and m_dat_o is zero, no matter what the slaves drive.
- R4: s_dat_o carries the byte of m_dat_i chosen by m_adr_i[1:0]: 0 gives bits 31:24, 1 gives 23:16, 2 gives 15:8 and 3 gives 7:0.
- R5: m_dat_o carries the selected slave's byte in the lane chosen by m_adr_i[1:0], using the mapping of R4. All other bits of m_dat_o are zero.
- R6: m_ack_o equals the s_ack_i bit of the selected slave. Acknowledges from slaves that are not selected have no effect.
- R7: m_err_o equals the s_err_i bit of the selected slave. Errors from slaves that are not selected have no effect.
- R8: s_adr_o always equals m_adr_i, and s_we_o always equals m_we_i.
- R9: While m_cyc_i is low, no slave is selected, and m_ack_o, m_err_o and m_dat_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_adr_i | input | AW | Master byte address |
| m_dat_i | input | 32 | Master write data word |
| m_we_i | input | 1 | Master write enable |
| m_cyc_i | input | 1 | Master bus cycle active |
| m_stb_i | input | 1 | Master strobe |
| m_dat_o | output | 32 | Read data, with the byte placed in its lane |
| m_ack_o | output | 1 | Acknowledge from the selected slave |
| m_err_o | output | 1 | Error from the selected slave |
| s_adr_o | output | AW | Address passed to all slaves |
| s_dat_o | output | 8 | Write byte passed to all slaves |
| s_we_o | output | 1 | Write enable passed to all slaves |
| s_cyc_o | output | N_SLV | Per-slave cycle, one-hot or zero |
| s_stb_o | output | N_SLV | Per-slave strobe |
| s_dat_i | input | N_SLV*8 | Slave read bytes, slave k in [k*8 +: 8] |
| s_ack_i | input | N_SLV | Slave acknowledges |
| s_err_i | input | N_SLV | Slave errors |

## Verification
The bench builds the bridge with overlapping windows, so that slave 3 covers the whole range of slaves 0 to 2. A priority encoder that picked the wrong end would then select slave 3, or both slaves, in the shared range. Each vector drives every slave's ack, err and data at random, so a return path that ORs unselected slaves together would show a spurious acknowledge or leaked data, most plainly on addresses that match no window. All four lanes are covered in both directions. A little-endian or off-by-one lane mapping would move the byte to the wrong quarter of the word or forward the wrong write byte.

// File: rtl/bbb_pkg.sv
package bbb_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned LANES   = WORD_W / BYTE_W;
  localparam int unsigned LANE_W  = $clog2(LANES);

  typedef logic [LANE_W-1:0] lane_t;

  // Big-endian: lane 0 is the most significant byte of the word.
  function automatic logic [4:0] lane_shift(input lane_t lane);
    lane_t rev;
    rev = lane_t'(LANES - 1) - lane;
    return {rev, 3'b000};
  endfunction

  function automatic logic [WORD_W-1:0] place_byte(input logic [BYTE_W-1:0] b,
                                                   input lane_t lane);
    logic [WORD_W-1:0] w;
    w = {{(WORD_W-BYTE_W){1'b0}}, b};
    return w << lane_shift(lane);
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] w,
                                                  input lane_t lane);
    logic [WORD_W-1:0] t;
    t = w >> lane_shift(lane);
    return t[BYTE_W-1:0];
  endfunction

endpackage

// File: rtl/bbb_decode.sv
module bbb_decode #(
  parameter int unsigned N_SLV = 4,
  parameter int unsigned AW    = 32,
  parameter logic [N_SLV*AW-1:0] SLV_BASE = '0,
  parameter logic [N_SLV*AW-1:0] SLV_MASK = '0
) (
  input  logic [AW-1:0]    adr,
  input  logic             cyc,
  output logic [N_SLV-1:0] hit,
  output logic [N_SLV-1:0] sel
);

  genvar k;
  generate
    for (k = 0; k < N_SLV; k++) begin : g_win
      assign hit[k] = ((adr & SLV_MASK[k*AW +: AW]) == SLV_BASE[k*AW +: AW]);
    end
  endgenerate

  // Lowest index wins among overlapping windows.
  logic taken;
  always_comb begin
    sel   = '0;
    taken = 1'b0;
    for (int i = 0; i < N_SLV; i++) begin
      if (cyc && hit[i] && !taken) begin
        sel[i] = 1'b1;
        taken  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/bbb_wr_steer.sv
module bbb_wr_steer
  import bbb_pkg::*;
(
  input  logic [WORD_W-1:0] wdata,
  input  lane_t             lane,
  output logic [BYTE_W-1:0] wbyte
);

  assign wbyte = pick_byte(wdata, lane);

endmodule

// File: rtl/bbb_rd_return.sv
module bbb_rd_return
  import bbb_pkg::*;
#(
  parameter int unsigned N_SLV = 4
) (
  input  logic [N_SLV-1:0]        sel,
  input  lane_t                   lane,
  input  logic [N_SLV*BYTE_W-1:0] s_rdata,
  input  logic [N_SLV-1:0]        s_ack,
  input  logic [N_SLV-1:0]        s_err,
  output logic [BYTE_W-1:0]       rbyte,
  output logic [WORD_W-1:0]       m_rdata,
  output logic                    m_ack,
  output logic                    m_err
);

  // sel is one-hot or zero, so an AND-OR tree is a plain mux.
  always_comb begin
    rbyte = '0;
    for (int i = 0; i < N_SLV; i++) begin
      rbyte = rbyte | (s_rdata[i*BYTE_W +: BYTE_W] & {BYTE_W{sel[i]}});
    end
  end

  assign m_rdata = place_byte(rbyte, lane);
  assign m_ack   = |(sel & s_ack);
  assign m_err   = |(sel & s_err);

endmodule

// File: rtl/byte_bus_bridge.sv
module byte_bus_bridge
  import bbb_pkg::*;
#(
  parameter int unsigned N_SLV = 4,
  parameter int unsigned AW    = 32,
  parameter logic [N_SLV*AW-1:0] SLV_BASE = {32'h9300_0000, 32'h9200_0000,
                                             32'h9100_0000, 32'h9000_0000},
  parameter logic [N_SLV*AW-1:0] SLV_MASK = {4{32'hFF00_0000}}
) (
  input  logic [AW-1:0]           m_adr_i,
  input  logic [WORD_W-1:0]       m_dat_i,
  input  logic                    m_we_i,
  input  logic                    m_cyc_i,
  input  logic                    m_stb_i,
  output logic [WORD_W-1:0]       m_dat_o,
  output logic                    m_ack_o,
  output logic                    m_err_o,
  output logic [AW-1:0]           s_adr_o,
  output logic [BYTE_W-1:0]       s_dat_o,
  output logic                    s_we_o,
  output logic [N_SLV-1:0]        s_cyc_o,
  output logic [N_SLV-1:0]        s_stb_o,
  input  logic [N_SLV*BYTE_W-1:0] s_dat_i,
  input  logic [N_SLV-1:0]        s_ack_i,
  input  logic [N_SLV-1:0]        s_err_i
);

  // Named internal events for the checker.
  lane_t             lane;
  logic [N_SLV-1:0]  win_hit;
  logic [N_SLV-1:0]  slv_sel;
  logic              any_sel;
  logic [BYTE_W-1:0] rd_byte;

  assign lane    = m_adr_i[LANE_W-1:0];
  assign any_sel = |slv_sel;

  bbb_decode #(
    .N_SLV   (N_SLV),
    .AW      (AW),
    .SLV_BASE(SLV_BASE),
    .SLV_MASK(SLV_MASK)
  ) u_decode (
    .adr(m_adr_i),
    .cyc(m_cyc_i),
    .hit(win_hit),
    .sel(slv_sel)
  );

  bbb_wr_steer u_wr (
    .wdata(m_dat_i),
    .lane (lane),
    .wbyte(s_dat_o)
  );

  bbb_rd_return #(.N_SLV(N_SLV)) u_rd (
    .sel    (slv_sel),
    .lane   (lane),
    .s_rdata(s_dat_i),
    .s_ack  (s_ack_i),
    .s_err  (s_err_i),
    .rbyte  (rd_byte),
    .m_rdata(m_dat_o),
    .m_ack  (m_ack_o),
    .m_err  (m_err_o)
  );

  assign s_adr_o = m_adr_i;
  assign s_we_o  = m_we_i;
  assign s_cyc_o = slv_sel;
  assign s_stb_o = slv_sel & {N_SLV{m_stb_i}};

endmodule

// File: rtl/bbb_checker.sv
module bbb_checker #(
  parameter int unsigned N_SLV = 4,
  parameter int unsigned AW    = 32
) (
  input logic [AW-1:0]    m_adr_i,
  input logic [31:0]      m_dat_i,
  input logic             m_cyc_i,
  input logic             m_stb_i,
  input logic [31:0]      m_dat_o,
  input logic             m_ack_o,
  input logic             m_err_o,
  input logic [7:0]       s_dat_o,
  input logic [N_SLV-1:0] s_cyc_o,
  input logic [N_SLV-1:0] s_stb_o,
  input logic [N_SLV-1:0] s_ack_i,
  input logic [N_SLV-1:0] s_err_i,
  input logic [N_SLV-1:0] win_hit,
  input logic             any_sel
);

  logic        known;
  logic [31:0] lane_mask;
  logic [7:0]  exp_wbyte;

  assign known = !$isunknown({m_adr_i, m_dat_i, m_cyc_i, m_stb_i, s_ack_i, s_err_i});

  always_comb begin
    case (m_adr_i[1:0])
      2'd0:    begin lane_mask = 32'hFF00_0000; exp_wbyte = m_dat_i[31:24]; end
      2'd1:    begin lane_mask = 32'h00FF_0000; exp_wbyte = m_dat_i[23:16]; end
      2'd2:    begin lane_mask = 32'h0000_FF00; exp_wbyte = m_dat_i[15:8];  end
      default: begin lane_mask = 32'h0000_00FF; exp_wbyte = m_dat_i[7:0];   end
    endcase
  end

  always_comb begin
    if (known) begin
      p_one_slave_r2: assert ($onehot0(s_cyc_o));
      p_sel_in_window_r1: assert ((s_cyc_o & ~win_hit) == '0);
      p_stb_inside_cyc_r1: assert ((s_stb_o & ~s_cyc_o) == '0);
      p_wbyte_lane_r4: assert (s_dat_o == exp_wbyte);
      p_rd_lane_only_r5: assert ((m_dat_o & ~lane_mask) == 32'h0);
      if (!any_sel) begin
        p_no_match_quiet_r3: assert (!m_ack_o && !m_err_o && m_dat_o == 32'h0);
      end
      if (m_ack_o) begin
        p_ack_from_sel_r6: assert ((s_cyc_o & s_ack_i) != '0);
      end
      if (m_err_o) begin
        p_err_from_sel_r7: assert ((s_cyc_o & s_err_i) != '0);
      end
      if (!m_cyc_i) begin
        p_idle_no_sel_r9: assert (s_cyc_o == '0 && !m_ack_o && !m_err_o);
      end
    end
  end

endmodule

bind byte_bus_bridge bbb_checker #(.N_SLV(N_SLV), .AW(AW)) u_bbb_chk (
  .m_adr_i(m_adr_i),
  .m_dat_i(m_dat_i),
  .m_cyc_i(m_cyc_i),
  .m_stb_i(m_stb_i),
  .m_dat_o(m_dat_o),
  .m_ack_o(m_ack_o),
  .m_err_o(m_err_o),
  .s_dat_o(s_dat_o),
  .s_cyc_o(s_cyc_o),
  .s_stb_o(s_stb_o),
  .s_ack_i(s_ack_i),
  .s_err_i(s_err_i),
  .win_hit(win_hit),
  .any_sel(any_sel)
);

// File: tb/test_byte_bus_bridge.sv
module test_byte_bus_bridge;

  localparam int N  = 4;
  localparam int AW = 32;
  // Slave 3 overlaps slaves 0..2 to exercise priority.
  localparam logic [N*AW-1:0] TB_BASE = {32'h9000_0000, 32'h9200_0000,
                                         32'h9100_0000, 32'h9000_0000};
  localparam logic [N*AW-1:0] TB_MASK = {32'hF000_0000, 32'hFF00_0000,
                                         32'hFF00_0000, 32'hFF00_0000};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [AW-1:0]  m_adr_i = '0;
  logic [31:0]    m_dat_i = '0;
  logic           m_we_i = 1'b0, m_cyc_i = 1'b0, m_stb_i = 1'b0;
  logic [31:0]    m_dat_o;
  logic           m_ack_o, m_err_o;
  logic [AW-1:0]  s_adr_o;
  logic [7:0]     s_dat_o;
  logic           s_we_o;
  logic [N-1:0]   s_cyc_o, s_stb_o;
  logic [N*8-1:0] s_dat_i = '0;
  logic [N-1:0]   s_ack_i = '0, s_err_i = '0;

  byte_bus_bridge #(.N_SLV(N), .AW(AW), .SLV_BASE(TB_BASE), .SLV_MASK(TB_MASK)) i_byte_bus_bridge (
    .m_adr_i(m_adr_i), .m_dat_i(m_dat_i), .m_we_i(m_we_i), .m_cyc_i(m_cyc_i),
    .m_stb_i(m_stb_i), .m_dat_o(m_dat_o), .m_ack_o(m_ack_o), .m_err_o(m_err_o),
    .s_adr_o(s_adr_o), .s_dat_o(s_dat_o), .s_we_o(s_we_o), .s_cyc_o(s_cyc_o),
    .s_stb_o(s_stb_o), .s_dat_i(s_dat_i), .s_ack_i(s_ack_i), .s_err_i(s_err_i)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Expected slave index, or -1; counts matching windows too.
  function automatic int exp_slave(input logic [31:0] adr, input logic cyc, output int nmatch);
    int found = -1;
    nmatch = 0;
    for (int k = 0; k < N; k++) begin
      if ((adr & TB_MASK[k*AW +: AW]) == TB_BASE[k*AW +: AW]) begin
        nmatch++;
        if (found < 0) found = k;
      end
    end
    return cyc ? found : -1;
  endfunction

  function automatic logic [7:0] lane_byte(input logic [31:0] w, input logic [1:0] l);
    case (l)
      2'd0: return w[31:24];
      2'd1: return w[23:16];
      2'd2: return w[15:8];
      default: return w[7:0];
    endcase
  endfunction

  function automatic logic [31:0] put_lane(input logic [7:0] b, input logic [1:0] l);
    case (l)
      2'd0: return {b, 24'h0};
      2'd1: return {8'h0, b, 16'h0};
      2'd2: return {16'h0, b, 8'h0};
      default: return {24'h0, b};
    endcase
  endfunction

  task automatic apply_and_check(input logic [31:0] adr, input logic [31:0] wd,
                                 input logic we, input logic cyc, input logic stb,
                                 input logic [N*8-1:0] sd, input logic [N-1:0] ack,
                                 input logic [N-1:0] err);
    int s, nm;
    string rq;
    logic [N-1:0] ecyc;
    @(negedge clk);
    m_adr_i = adr; m_dat_i = wd; m_we_i = we; m_cyc_i = cyc; m_stb_i = stb;
    s_dat_i = sd; s_ack_i = ack; s_err_i = err;
    #5;
    s = exp_slave(adr, cyc, nm);
    ecyc = '0;
    if (s >= 0) ecyc[s] = 1'b1;
    if (!cyc) rq = "R9";
    else if (nm == 0) rq = "R3";
    else if (nm > 1) rq = "R2";
    else rq = "R1";
    chk(rq, "s_cyc_o", 32'(s_cyc_o), 32'(ecyc));
    chk(rq, "s_stb_o", 32'(s_stb_o), 32'(ecyc & {N{stb}}));
    chk("R4", "s_dat_o", 32'(s_dat_o), 32'(lane_byte(wd, adr[1:0])));
    chk("R8", "s_adr_o", s_adr_o, adr);
    chk("R8", "s_we_o", 32'(s_we_o), 32'(we));
    if (s >= 0) begin
      chk("R5", "m_dat_o", m_dat_o, put_lane(sd[s*8 +: 8], adr[1:0]));
      chk("R6", "m_ack_o", 32'(m_ack_o), 32'(ack[s]));
      chk("R7", "m_err_o", 32'(m_err_o), 32'(err[s]));
    end else begin
      chk(rq, "m_dat_o idle", m_dat_o, 32'h0);
      chk(rq, "m_ack_o idle", 32'(m_ack_o), 32'h0);
      chk(rq, "m_err_o idle", 32'(m_err_o), 32'h0);
    end
  endtask

  initial begin
    logic [7:0] top_b;
    void'($urandom(32'd2024));
    // Initial state: cycle low, nothing selected (R9).
    #5;
    chk("R9", "initial s_cyc_o", 32'(s_cyc_o), 32'h0);
    chk("R9", "initial m_ack_o", 32'(m_ack_o), 32'h0);
    // R5/R4: each lane, slave 1.
    for (int l = 0; l < 4; l++)
      apply_and_check(32'h9100_0000 | 32'(l), 32'hA1B2_C3D4, 1'b0, 1'b1, 1'b1,
                      32'h44_33_5A_11, 4'b0010, 4'b0000);
    // R6: only unselected slaves acknowledge -> no ack.
    apply_and_check(32'h9200_0002, 32'h0, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF, 4'b1011, 4'b1011);
    // R7: selected slave errors.
    apply_and_check(32'h9000_0003, 32'h0, 1'b1, 1'b1, 1'b1, 32'h0102_0304, 4'b0001, 4'b0001);
    // R2: overlap region, slave 0 wins over slave 3.
    apply_and_check(32'h9000_0001, 32'h1234_5678, 1'b1, 1'b1, 1'b1, 32'h77_00_00_66, 4'b1111, 4'b0000);
    // R2: only slave 3's wide window.
    apply_and_check(32'h9700_0000, 32'h0, 1'b0, 1'b1, 1'b1, 32'hAB00_0000, 4'b1000, 4'b0000);
    // R3: no window, every slave answering.
    apply_and_check(32'h4000_0001, 32'hDEAD_BEEF, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF, 4'b1111, 4'b1111);
    // R9: cycle low with matching address.
    apply_and_check(32'h9100_0000, 32'h0, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF, 4'b1111, 4'b1111);
    // Random mix.
    for (int i = 0; i < 500; i++) begin
      case ($urandom % 6)
        0: top_b = 8'h90;
        1: top_b = 8'h91;
        2: top_b = 8'h92;
        3: top_b = 8'h97;
        4: top_b = 8'h9C;
        default: top_b = 8'($urandom);
      endcase
      apply_and_check({top_b, 24'($urandom)}, $urandom, 1'($urandom),
                      ($urandom % 8) != 0, 1'($urandom), $urandom,
                      4'($urandom), 4'($urandom));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule